// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (LSB-First, 128 Bytes)

This block acts as the slave side of a minimal two-wire serial memory holding 128 bytes in an internal register array. The clock and data line levels from the bus are brought into the system clock domain through a two-flop synchronizer. Start and stop conditions are then recognised by comparing each sample with the one before it.

A transfer opens with a single control byte. Its first seven bits form the word address, sent least-significant bit first, and its eighth bit selects the direction. After the block acknowledges, it either shifts out the addressed byte or takes in exactly one byte and stores it. Data always moves least-significant bit first. The data line is driven open-drain: the block only ever pulls it low, and `sda_out` shows the level the block contributes, which is 1 when released. The `sda_in` input carries the level the bus master presents.

Top module: `tw_eeprom_lsb`

## Requirements
- R1: After reset the block releases the data line (`sda_out` = 1, `sda_oe` = 0) and is idle.
- R2: The control byte is taken on SCL rising edges: bits 0..6 of the word address in that order, then a direction bit (1 = read, 0 = write). On the SCL rise after these eight bits the block drives SDA low, and it releases SDA at the following SCL fall.
- R3: In a write, the eight data bits following the acknowledge are captured on SCL rising edges, bit 0 first, and stored at the addressed location.
- R4: In a read, the addressed byte appears on SDA one bit per SCL rising edge, bit 0 first, each bit held while SCL is high. The drive level changes only after a sampled SCL or SDA transition.
- R5: A write stores exactly one byte. The block acknowledges it, goes idle, and neither acknowledges nor stores further bits clocked in before the next start.
- R6: A stop (SDA rising while SCL was high) returns the block to idle and releases SDA. Bits clocked after it are ignored until a start.
- R7: A start (SDA falling while SCL was high), in any state, releases SDA, clears the partially received address and begins a new control byte.
- R8: All 128 word addresses, 0 through 127, are independent storage locations.
- R9: While idle, the block never drives SDA low.
- R10: After the eighth read bit, the block keeps its last data-bit level on SDA and shifts no further bits until a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| sda_in | input | 1 | Data line level presented by the master, asynchronous |
| sda_oe | output | 1 | High when the block pulls the data line low |
| sda_out | output | 1 | Data level contributed by the block, 1 when released |

## Verification
The hardest situations to reach from the ports are a start arriving partway through a control byte and the quiet interval after a single-byte write. The first needs a prefix whose address bits would corrupt the next address if they were not cleared. The second needs further clocking after the write has been acknowledged. The bench first sends a partial address of all ones and then a repeated start, so that a stale bit would redirect the read to a different location with a different value. After a write it clocks nine more bits and reads back both the target location and its neighbour. Every line change is held for eight system clocks, well beyond the three-cycle path through the synchronizer, so each sample is taken after the block has settled.

// File: rtl/tw_eeprom_lsb.sv
module tw_eeprom_lsb #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe,
  output logic sda_out
);
  localparam int ADDR_W = DATA_W - 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = IDX_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_READ, S_WRITE, S_AWAIT} state_t;

  logic [1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_p, sda_p;
  state_t st, nxt;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dat;
  logic rel;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '0;
      sda_sync <= '0;
      scl_p    <= 1'b0;
      sda_p    <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  assign scl_s = scl_sync[1];
  assign sda_s = sda_sync[1];

  logic start_c, stop_c, rise_c, fall_c, full, in_idle, wr_en;
  logic [IDX_W-1:0] idx;

  assign start_c = scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_p & ~sda_p & sda_s;
  assign rise_c  = ~scl_p & scl_s & ~start_c & ~stop_c;
  assign fall_c  = scl_p & ~scl_s & ~start_c & ~stop_c;
  assign full    = cnt >= CNT_W'(DATA_W);
  assign idx     = cnt[IDX_W-1:0];
  assign in_idle = (st == S_IDLE);
  assign wr_en   = fall_c && st == S_WRITE && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      nxt  <= S_IDLE;
      cnt  <= '0;
      addr <= '0;
      dat  <= '0;
      rel  <= 1'b1;
    end else if (start_c) begin
      st   <= S_ADDR;
      cnt  <= '0;
      addr <= '0;
      rel  <= 1'b1;
    end else if (stop_c) begin
      st   <= S_IDLE;
      rel  <= 1'b1;
    end else if (rise_c) begin
      case (st)
        S_ADDR: begin
          if (cnt < CNT_W'(ADDR_W)) addr[idx] <= sda_s;
          else if (sda_s) begin
            nxt <= S_READ;
            dat <= mem[addr];
          end else nxt <= S_WRITE;
          cnt <= cnt + CNT_W'(1);
        end
        S_ACK: rel <= 1'b0;
        S_READ: begin
          if (!full) rel <= dat[idx];
          cnt <= cnt + CNT_W'(1);
        end
        S_WRITE: begin
          if (!full) dat[idx] <= sda_s;
          cnt <= cnt + CNT_W'(1);
        end
        S_AWAIT: if (!sda_s) nxt <= S_IDLE;
        default: ;
      endcase
    end else if (fall_c) begin
      case (st)
        S_ADDR: if (full) begin
          st  <= S_ACK;
          rel <= 1'b1;
        end
        S_ACK: begin
          st  <= nxt;
          cnt <= '0;
          rel <= 1'b1;
        end
        S_READ: if (full) begin
          st   <= S_AWAIT;
          addr <= addr + ADDR_W'(1);
        end
        S_WRITE: if (full) begin
          st   <= S_ACK;
          nxt  <= S_IDLE;
          addr <= addr + ADDR_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= dat;
  end

  assign sda_out = rel;
  assign sda_oe  = ~rel;
endmodule

// File: rtl/tw_eeprom_lsb_chk.sv
module tw_eeprom_lsb_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_s,
  input logic scl_p,
  input logic sda_p,
  input logic in_idle,
  input logic sda_oe
);
  // R2
  pull_low_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ($past(scl_s) && !$past(scl_p)));
  // R4
  drive_moves_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (($past(scl_s) != $past(scl_p)) || ($past(sda_s) != $past(sda_p))));
  // R6
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_p && !sda_p && sda_s) |=> !sda_oe);
  // R7
  start_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_p && sda_p && !sda_s) |=> !sda_oe);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);
endmodule

bind tw_eeprom_lsb tw_eeprom_lsb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
  .scl_p(scl_p), .sda_p(sda_p), .in_idle(in_idle), .sda_oe(sda_oe)
);

// File: tb/tw_eeprom_lsb_test.sv
module tw_eeprom_lsb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic sda_oe, sda_out;
  int checks = 0;
  int errors = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  tw_eeprom_lsb uut (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
                     .sda_oe(sda_oe), .sda_out(sda_out));

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_scl(logic v);
    @(negedge clk); scl = v; repeat (8) @(negedge clk);
  endtask

  task automatic set_sda(logic v);
    @(negedge clk); sda = v; repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    set_sda(1'b1); set_scl(1'b1); set_sda(1'b0); set_scl(1'b0);
  endtask

  task automatic bus_stop();
    set_scl(1'b0); set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
  endtask

  task automatic clk_bit(logic b);
    set_sda(b); set_scl(1'b1); set_scl(1'b0);
  endtask

  task automatic send_ctrl(logic [6:0] a, logic rw);
    for (int i = 0; i < 7; i++) clk_bit(a[i]);
    clk_bit(rw);
  endtask

  task automatic ack_slot(string req);
    set_sda(1'b1); set_scl(1'b1);
    check(req, "ack low", {7'd0, sda_out}, 8'd0);
    set_scl(1'b0);
    check(req, "ack released", {7'd0, sda_out}, 8'd1);
  endtask

  task automatic read_bits(output logic [7:0] d);
    set_sda(1'b1);
    for (int i = 0; i < 8; i++) begin
      set_scl(1'b1); d[i] = sda_out; set_scl(1'b0);
    end
  endtask

  task automatic quiet_pulses(string req, logic [7:0] d, int n);
    set_scl(1'b0);
    for (int i = 0; i < n; i++) begin
      set_sda(d[i % 8]); set_scl(1'b1);
      check(req, "line released", {7'd0, sda_out}, 8'd1);
      set_scl(1'b0);
    end
  endtask

  task automatic do_write(logic [6:0] a, logic [7:0] d);
    bus_start(); send_ctrl(a, 1'b0); ack_slot("R2");
    for (int i = 0; i < 8; i++) clk_bit(d[i]);
    ack_slot("R5"); bus_stop();
  endtask

  task automatic do_read(logic [6:0] a, output logic [7:0] d);
    bus_start(); send_ctrl(a, 1'b1); ack_slot("R2");
    read_bits(d);
    set_sda(1'b0); set_scl(1'b1); set_scl(1'b0);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1", "sda_out", {7'd0, sda_out}, 8'd1);
    check("R1", "sda_oe", {7'd0, sda_oe}, 8'd0);
    quiet_pulses("R9", 8'h00, 9);
  endtask

  task automatic t_write_read();
    do_write(7'd5, 8'hA5); do_write(7'd0, 8'h01); do_write(7'd127, 8'h80);
    do_write(7'd64, 8'h3C); do_write(7'd11, 8'h77);
    do_read(7'd5, got);   check("R4", "read addr 5 LSB first", got, 8'hA5);
    do_read(7'd0, got);   check("R8", "read addr 0", got, 8'h01);
    do_read(7'd127, got); check("R8", "read addr 127", got, 8'h80);
    do_read(7'd64, got);  check("R3", "read addr 64", got, 8'h3C);
    do_read(7'd11, got);  check("R3", "read addr 11", got, 8'h77);
  endtask

  task automatic t_single_byte();
    bus_start(); send_ctrl(7'd10, 1'b0); ack_slot("R2");
    for (int i = 0; i < 8; i++) clk_bit(8'h11 >> i);
    ack_slot("R5");
    quiet_pulses("R5", 8'h22, 9);
    bus_stop();
    do_read(7'd10, got); check("R5", "stored byte", got, 8'h11);
    do_read(7'd11, got); check("R5", "neighbour untouched", got, 8'h77);
  endtask

  task automatic t_stop_abort();
    bus_start();
    for (int i = 0; i < 3; i++) clk_bit(1'b1);
    bus_stop();
    check("R6", "released after stop", {7'd0, sda_out}, 8'd1);
    quiet_pulses("R6", 8'h00, 9);
  endtask

  task automatic t_restart();
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    set_scl(1'b0);
    bus_start();
    check("R7", "released after start", {7'd0, sda_out}, 8'd1);
    send_ctrl(7'd5, 1'b1); ack_slot("R7");
    read_bits(got);
    check("R7", "read after restart", got, 8'hA5);
    set_sda(1'b0); set_scl(1'b1); set_scl(1'b0);
    bus_stop();
  endtask

  task automatic t_hold_after_read();
    bus_start(); send_ctrl(7'd64, 1'b1); ack_slot("R2");
    read_bits(got);
    check("R10", "byte", got, 8'h3C);
    for (int i = 0; i < 3; i++) begin
      set_scl(1'b1);
      check("R10", "held last bit", {7'd0, sda_out}, 8'd0);
      set_scl(1'b0);
    end
    bus_stop();
    check("R6", "released after stop", {7'd0, sda_out}, 8'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_single_byte();
    t_stop_abort();
    t_restart();
    t_hold_after_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule